// File: doc/BRIEF.md
# Host Controller Interrupt Status Unit

This block gathers single-cycle event pulses from a storage host controller's command path, data path, DMA engine and card-detect logic. It holds them in two 16-bit status registers: one for normal events and one for errors. Each status register has two masks with the same bit layout. The status-enable mask decides whether an event is recorded at all. The signal-enable mask decides whether a recorded bit drives the single interrupt line.

Software reaches six registers through a small read/write port. Recorded bits are cleared by writing 1 to them. The normal register carries a read-only summary bit that is set whenever any error bit is set. Three combinational outputs group the latched errors into a command class, a data class and their union, the transfer class.

Top module: `sd_irq_status_unit`

## Requirements
- R1: After reset, every register reads 0, and `irq_o`, `cmd_err_o`, `dat_err_o` and `xfer_err_o` are 0.
- R2: An event pulse sets its status bit at the next clock edge only if the matching status-enable bit is 1. With that enable bit at 0, the pulse leaves the status register unchanged.
- R3: Writing 1 to a latched status bit clears it at the next edge. Writing 0 leaves it unchanged.
- R4: If an event and a write-1 clear reach the same bit in the same cycle, the bit is set after the edge.
- R5: Normal bit 8 (card interrupt) equals `card_irq_i` AND status-enable bit 8. It is not latched, and writing 1 to it has no effect.
- R6: Normal bit 15 reads 1 exactly when any error status bit is set. Writing 1 to it does not clear it.
- R7: `irq_o` is 1 exactly when some normal status bit is set together with its normal signal-enable bit, or some error status bit is set together with its error signal-enable bit.
- R8: `cmd_err_o` is the OR of error bits 3:0. `dat_err_o` is the OR of error bits 4, 5, 6 and 9. `xfer_err_o` is their OR. Error bits 7 and 8 feed none of the three.
- R9: Latched normal bits are 0 to 7 and 12. Latched error bits are 0 to 9 and 12 to 15. Normal bits 9 to 11, 13 and 14, and error bits 10 and 11, always read 0.
- R10: Address map: 0 normal status, 1 error status, 2 normal status-enable, 3 error status-enable, 4 normal signal-enable, 5 error signal-enable. Mask registers read back what was written. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nrm_evt_i | input | 16 | Normal event pulses, one per normal bit |
| err_evt_i | input | 16 | Error event pulses, one per error bit |
| card_irq_i | input | 1 | Card interrupt level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt line |
| cmd_err_o | output | 1 | Command-class error present |
| dat_err_o | output | 1 | Data-class error present |
| xfer_err_o | output | 1 | Transfer-class error present |

## Verification
An event pulse or a register write applied during cycle N shows in the status and mask registers right after edge N+1. The summary bit, the error groups and `irq_o` are combinational from those registers, so they are due in the same cycle. The card interrupt bit is combinational from its input and can be read straight away. The bench drives every input on the falling edge and holds it through the next rising edge. It then samples on the following falling edge, or 1 ns after an address or level change, so each value is read after the one edge it depends on.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  localparam int NRM_CARD_BIT = 8;
  localparam int NRM_SUM_BIT  = 15;

  // latched bit sets
  localparam logic [REG_W-1:0] NRM_LATCH_MASK = 16'h10FF;
  localparam logic [REG_W-1:0] ERR_LATCH_MASK = 16'hF3FF;

  // error classes
  localparam logic [REG_W-1:0] ERR_CMD_GRP = 16'h000F;
  localparam logic [REG_W-1:0] ERR_DAT_GRP = 16'h0270;

  typedef enum logic [ADDR_W-1:0] {
    A_NRM_ST  = 3'd0,
    A_ERR_ST  = 3'd1,
    A_NRM_SEN = 3'd2,
    A_ERR_SEN = 3'd3,
    A_NRM_SIG = 3'd4,
    A_ERR_SIG = 3'd5
  } reg_addr_e;

  localparam int NUM_MASKS = 4;
  localparam int MASK_BASE = 2;
endpackage

// File: rtl/sd_irq_latch_reg.sv
module sd_irq_latch_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] set_m;
  logic [W-1:0] clr_m;
  assign set_m = evt_i & en_i & IMPL_MASK;
  assign clr_m = clr_i & IMPL_MASK;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q_q <= 1'b0;
        else if (set_m[b]) q_q <= 1'b1;   // event beats clear
        else if (clr_m[b]) q_q <= 1'b0;
      end
      assign q_o[b] = q_q;
    end else begin : g_tie
      assign q_o[b] = 1'b0;
    end
  end

  p_set_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & ~$past(q_o) & ~$past(set_m)) == '0));
  p_w1c_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_m & ~set_m) != '0) |=> ((q_o & $past(clr_m & ~set_m)) == '0));
  p_hold_w0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((~q_o) & $past(q_o) & ~$past(clr_m)) == '0));
  p_event_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_m != '0) |=> ((q_o & $past(set_m)) == $past(set_m)));
  p_unimpl_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & ~IMPL_MASK) == '0);
endmodule

// File: rtl/sd_irq_mask_bank.sv
module sd_irq_mask_bank
  import sd_irq_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [REG_W-1:0]               wdata_i,
  output logic [NUM_MASKS-1:0][REG_W-1:0] mask_o
);
  for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(MASK_BASE + m);
    logic [REG_W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q_q <= '0;
      else if (we_i && addr_i == MY_ADDR)  q_q <= wdata_i;
    end
    assign mask_o[m] = q_q;

    p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == MY_ADDR) |=> $stable(mask_o[m]));
  end
endmodule

// File: rtl/sd_irq_err_class.sv
module sd_irq_err_class
  import sd_irq_pkg::*;
(
  input  logic [REG_W-1:0] err_i,
  output logic             cmd_o,
  output logic             dat_o,
  output logic             xfer_o
);
  assign cmd_o  = |(err_i & ERR_CMD_GRP);
  assign dat_o  = |(err_i & ERR_DAT_GRP);
  assign xfer_o = cmd_o | dat_o;

  always_comb begin
    p_class_union_r8: assert (!(cmd_o || dat_o) || xfer_o);
  end
endmodule

// File: rtl/sd_irq_status_unit.sv
module sd_irq_status_unit
  import sd_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  nrm_evt_i,
  input  logic [REG_W-1:0]  err_evt_i,
  input  logic              card_irq_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              cmd_err_o,
  output logic              dat_err_o,
  output logic              xfer_err_o
);
  logic [NUM_MASKS-1:0][REG_W-1:0] masks;
  logic [REG_W-1:0] nrm_sen, err_sen, nrm_sig, err_sig;
  logic [REG_W-1:0] nrm_clr, err_clr;
  logic [REG_W-1:0] nrm_lat, err_st, nrm_st;

  assign nrm_sen = masks[A_NRM_SEN - MASK_BASE];
  assign err_sen = masks[A_ERR_SEN - MASK_BASE];
  assign nrm_sig = masks[A_NRM_SIG - MASK_BASE];
  assign err_sig = masks[A_ERR_SIG - MASK_BASE];

  assign nrm_clr = (reg_we_i && reg_addr_i == A_NRM_ST) ? reg_wdata_i : '0;
  assign err_clr = (reg_we_i && reg_addr_i == A_ERR_ST) ? reg_wdata_i : '0;

  sd_irq_mask_bank u_masks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .mask_o  (masks)
  );

  sd_irq_latch_reg #(.W(REG_W), .IMPL_MASK(NRM_LATCH_MASK)) u_nrm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (nrm_evt_i),
    .en_i   (nrm_sen),
    .clr_i  (nrm_clr),
    .q_o    (nrm_lat)
  );

  sd_irq_latch_reg #(.W(REG_W), .IMPL_MASK(ERR_LATCH_MASK)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (err_evt_i),
    .en_i   (err_sen),
    .clr_i  (err_clr),
    .q_o    (err_st)
  );

  always_comb begin
    nrm_st               = nrm_lat;
    nrm_st[NRM_CARD_BIT] = card_irq_i & nrm_sen[NRM_CARD_BIT];
    nrm_st[NRM_SUM_BIT]  = |err_st;
  end

  sd_irq_err_class u_class (
    .err_i  (err_st),
    .cmd_o  (cmd_err_o),
    .dat_o  (dat_err_o),
    .xfer_o (xfer_err_o)
  );

  assign irq_o = |(nrm_st & nrm_sig) | |(err_st & err_sig);

  always_comb begin
    unique case (reg_addr_i)
      A_NRM_ST:  reg_rdata_o = nrm_st;
      A_ERR_ST:  reg_rdata_o = err_st;
      A_NRM_SEN: reg_rdata_o = nrm_sen;
      A_ERR_SEN: reg_rdata_o = err_sen;
      A_NRM_SIG: reg_rdata_o = nrm_sig;
      A_ERR_SIG: reg_rdata_o = err_sig;
      default:   reg_rdata_o = '0;
    endcase
  end

  p_sum_tracks_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrm_st[NRM_SUM_BIT] == (err_st != '0));
  p_card_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nrm_sen[NRM_CARD_BIT] |-> !nrm_st[NRM_CARD_BIT]);
  p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrm_sig == '0 && err_sig == '0) |-> !irq_o);
  p_irq_needs_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (nrm_st != '0 || err_st != '0));
  p_cmd_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> nrm_st[NRM_SUM_BIT]);
endmodule

// File: tb/sd_irq_status_unit_tb_top.sv
module sd_irq_status_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] nrm_evt_i = '0;
  logic [15:0] err_evt_i = '0;
  logic        card_irq_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o, cmd_err_o, dat_err_o, xfer_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sd_irq_status_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .nrm_evt_i(nrm_evt_i), .err_evt_i(err_evt_i),
    .card_irq_i(card_irq_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .cmd_err_o(cmd_err_o), .dat_err_o(dat_err_o), .xfer_err_o(xfer_err_o)
  );

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [15:0] n, input logic [15:0] e);
    @(negedge clk_i);
    nrm_evt_i = n; err_evt_i = e;
    @(negedge clk_i);
    nrm_evt_i = '0; err_evt_i = '0;
  endtask

  task automatic clear_all();
    wr(3'd1, 16'hFFFF);
    wr(3'd0, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1", $sformatf("reg %0d after reset", a), d, 16'h0);
    end
    check("R1", "irq after reset", {15'b0, irq_o}, 16'h0);
    check("R1", "groups after reset", {13'b0, cmd_err_o, dat_err_o, xfer_err_o}, 16'h0);
  endtask

  task automatic t_latch_gate();
    logic [15:0] d;
    pulse(16'hFFFF, 16'hFFFF);
    rd(3'd0, d); check("R2", "normal event with enable 0", d, 16'h0);
    rd(3'd1, d); check("R2", "error event with enable 0", d, 16'h0);
    wr(3'd2, 16'hFFFF);
    pulse(16'hFFFF, 16'h0);
    rd(3'd0, d); check("R9", "normal latched set", d, 16'h10FF);
    wr(3'd3, 16'hFFFF);
    pulse(16'h0, 16'hFFFF);
    rd(3'd1, d); check("R9", "error latched set", d, 16'hF3FF);
    rd(3'd0, d); check("R2", "normal after error latch", d, 16'h90FF);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    wr(3'd0, 16'h0000);
    rd(3'd0, d); check("R3", "write 0 keeps bits", d, 16'h90FF);
    wr(3'd0, 16'h0003);
    rd(3'd0, d); check("R3", "write 1 clears bits 1:0", d, 16'h90FC);
    wr(3'd1, 16'h000F);
    rd(3'd1, d); check("R3", "error w1c", d, 16'hF3F0);
  endtask

  task automatic t_summary();
    logic [15:0] d;
    wr(3'd0, 16'h8000);
    rd(3'd0, d); check("R6", "summary not cleared by write", d, 16'h90FC);
    wr(3'd1, 16'hFFFF);
    rd(3'd0, d); check("R6", "summary drops with errors", d, 16'h10FC);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, d); check("R3", "full normal clear", d, 16'h0);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    pulse(16'h0002, 16'h0);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 16'h0003; nrm_evt_i = 16'h0001;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0; nrm_evt_i = '0;
    rd(3'd0, d); check("R4", "event beats clear", d, 16'h0001);
    wr(3'd0, 16'hFFFF);
  endtask

  task automatic t_card();
    logic [15:0] d;
    card_irq_i = 1'b1;
    rd(3'd0, d); check("R5", "card bit follows level", d, 16'h0100);
    wr(3'd0, 16'h0100);
    rd(3'd0, d); check("R5", "card bit ignores w1c", d, 16'h0100);
    card_irq_i = 1'b0;
    rd(3'd0, d); check("R5", "card bit drops with level", d, 16'h0000);
    wr(3'd2, 16'hFEFF);
    card_irq_i = 1'b1;
    rd(3'd0, d); check("R5", "card bit gated by enable", d, 16'h0000);
    card_irq_i = 1'b0;
    wr(3'd2, 16'hFFFF);
  endtask

  task automatic t_irq();
    pulse(16'h0002, 16'h0);
    check("R7", "status set, no signal enable", {15'b0, irq_o}, 16'h0);
    wr(3'd4, 16'h0002);
    check("R7", "normal signal enable", {15'b0, irq_o}, 16'h1);
    wr(3'd0, 16'h0002);
    check("R7", "irq drops on clear", {15'b0, irq_o}, 16'h0);
    pulse(16'h0, 16'h0010);
    check("R7", "error without enable", {15'b0, irq_o}, 16'h0);
    wr(3'd4, 16'h8000);
    check("R7", "error via summary bit", {15'b0, irq_o}, 16'h1);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0010);
    check("R7", "error signal enable", {15'b0, irq_o}, 16'h1);
    wr(3'd5, 16'h0001);
    check("R7", "other error enable", {15'b0, irq_o}, 16'h0);
    wr(3'd5, 16'h0000);
    clear_all();
  endtask

  task automatic t_groups();
    pulse(16'h0, 16'h0004);
    check("R8", "cmd end-bit error", {13'b0, cmd_err_o, dat_err_o, xfer_err_o}, 16'h5);
    clear_all();
    pulse(16'h0, 16'h0200);
    check("R8", "dma error is data class", {13'b0, cmd_err_o, dat_err_o, xfer_err_o}, 16'h3);
    clear_all();
    pulse(16'h0, 16'h0180);
    check("R8", "bits 7,8 in no class", {13'b0, cmd_err_o, dat_err_o, xfer_err_o}, 16'h0);
    clear_all();
  endtask

  task automatic t_addr();
    logic [15:0] d;
    wr(3'd4, 16'hA5A5);
    rd(3'd4, d); check("R10", "normal signal mask readback", d, 16'hA5A5);
    wr(3'd3, 16'h5A5A);
    rd(3'd3, d); check("R10", "error status mask readback", d, 16'h5A5A);
    rd(3'd6, d); check("R10", "address 6 reads 0", d, 16'h0);
    rd(3'd7, d); check("R10", "address 7 reads 0", d, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_latch_gate();
    t_w1c();
    t_summary();
    t_collision();
    t_card();
    t_irq();
    t_groups();
    t_addr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule